// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block lets software switch four on-chip power domains on and off through a small 32-bit register bus. Each domain owns a bank of four registers: a settled-state register, a switch-off command register, a switch-on command register and a retry-flag register. A global register tells software whether a command of each direction can be taken now. Interrupt-status, interrupt-clear, interrupt-enable and interrupt-mask registers report finished transitions.

A command is a write of a single channel bit into a domain's command register. The domain then counts through a transition that lasts a set number of clock cycles. When the count ends, the domain's settled state flips and a sticky completion bit is latched. A test input can make the next command fail, so that software's retry path can be exercised. Software normally polls the ready and status registers. The interrupt line is there for designs that prefer to wait on it.

Top module: `pdsc_top`

## Requirements
- R1: After reset, every domain status register reads 1 in bit CH_BIT (domain off). The ready register reads 0x3. Interrupt status, every error register, the enable and mask registers and the irq output are all 0.
- R2: A command is accepted only when all of these hold: the write goes to a domain's switch-off register (domain base + 0x04) or switch-on register (domain base + 0x0C); the data word has only bit CH_BIT set (default bit 0); the ready bit for that direction is 1; the domain is idle. A write with any other data value has no effect.
- R3: The ready register sits at 0x000. Bit 0 allows switch-off commands and bit 1 allows switch-on commands. After an accepted command, the matching bit reads 0 from the next cycle. It returns to 1 at the clock edge LATENCY cycles after the accepting edge. A command written while its ready bit is 0 is ignored.
- R4: A domain's status register (base + 0x00) reads 1 in bit CH_BIT when the domain is off. It keeps its old value during a transition and takes the new value at the edge LATENCY cycles after the accepting edge.
- R5: The interrupt-status register sits at 0x004. The domains with bases 0x080, 0x0C0, 0x100 and 0x140 own bits 16, 20, 21 and 24 respectively. A domain's bit is set when that domain completes a transition, and it stays set until it is cleared.
- R6: Writing to the clear register at 0x008 clears each interrupt-status bit whose data bit is 1. Data bits that are 0 leave the status unchanged. If a completion and a clear of the same bit fall in the same cycle, the completion wins.
- R7: A one-cycle pulse on err_inject arms a single failure. The next command that would otherwise be accepted instead sets bit CH_BIT of that domain's error register (base + 0x14). That command starts no transition and leaves the ready bits at 1. The next accepted command for that domain clears the error bit.
- R8: irq is high whenever some interrupt-status bit is set in the enable register (0x00C) and clear in the mask register (0x010). The enable register stores a written value such as 0x0131000E and reads it back.
- R9: A read of an unmapped address, a command register or the clear register returns 0. A write to an unmapped address changes nothing.
- R10: A read strobe returns the addressed register on bus_rdata at the next clock edge. bus_rdata holds its value when no read is made.
- R11: A command to a domain that is mid-transition is ignored, even when the ready bit for the other direction is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| err_inject | input | 1 | Arms a single failure of the next command |
| irq | output | 1 | Enabled, unmasked completion pending |

## Verification
Two events can land on the same interrupt-status bit in the same cycle: a domain finishing its transition, and a software write to the clear register. The bench provokes this by issuing a switch-on to the fourth domain, waiting exactly LATENCY-1 cycles, and then writing a clear for bit 24 so that the write lands on the completion edge. The bench expects the bit to stay set afterwards, because the completion has priority. A second overlap is a command that arrives while another domain is busy. The bench judges that overlap from the ready register and from the status of the domain it targeted.

// File: rtl/pdsc_pkg.sv
// Shared widths, register offsets and the per-domain placement table of the
// power domain sequencing controller. Assumes byte addressing of 32-bit words.
package pdsc_pkg;
    localparam int NDOM = 4;
    localparam int AW   = 12;
    localparam int DW   = 32;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] word_t;

    // Global registers
    localparam addr_t A_READY = 12'h000;
    localparam addr_t A_ISTAT = 12'h004;
    localparam addr_t A_ICLR  = 12'h008;
    localparam addr_t A_IEN   = 12'h00C;
    localparam addr_t A_IMASK = 12'h010;

    // Offsets inside one domain bank
    localparam addr_t O_STAT = 12'h000;
    localparam addr_t O_OFF  = 12'h004;
    localparam addr_t O_ON   = 12'h00C;
    localparam addr_t O_ERR  = 12'h014;

    // Base address of a domain bank
    function automatic addr_t dom_base(input int d);
        case (d)
            0:       return 12'h080;
            1:       return 12'h0C0;
            2:       return 12'h100;
            default: return 12'h140;
        endcase
    endfunction

    // Completion bit of a domain in the interrupt-status word
    function automatic int dom_irq_bit(input int d);
        case (d)
            0:       return 16;
            1:       return 20;
            2:       return 21;
            default: return 24;
        endcase
    endfunction
endpackage

// File: rtl/pdsc_domain.sv
// One power domain: holds its settled on/off state and counts a transition of
// LATENCY cycles after a start strobe. Assumes go_off/go_on arrive only while
// idle and never together; fail marks a command rejected by error injection.
module pdsc_domain #(
    parameter int LATENCY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_off,
    input  logic go_on,
    input  logic fail,
    output logic is_off,
    output logic busy,
    output logic dir_on,
    output logic err,
    output logic done
);
    localparam int CW = $clog2(LATENCY + 1);

    logic [CW-1:0] cnt;

    // Last cycle of a running transition
    assign done = busy && (cnt == '0);

    // Transition sequencing, settled state and retry flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            dir_on <= 1'b0;
            cnt    <= '0;
            is_off <= 1'b1;
            err    <= 1'b0;
        end else begin
            if (go_off || go_on) begin
                busy   <= 1'b1;
                dir_on <= go_on;
                cnt    <= CW'(LATENCY - 1);
                err    <= 1'b0;
            end else if (busy) begin
                if (cnt == '0) begin
                    busy   <= 1'b0;
                    is_off <= !dir_on;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
            if (fail) begin
                err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pdsc_irq.sv
// Sticky completion flags with write-one-to-clear, plus enable and mask
// registers that form the interrupt line. A set and a clear of the same bit in
// one cycle leave the bit set.
module pdsc_irq
    import pdsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t set_vec,
    input  logic  clr_we,
    input  logic  en_we,
    input  logic  mask_we,
    input  word_t wdata,
    output word_t stat,
    output word_t en,
    output word_t mask,
    output logic  irq
);
    word_t clr_vec;

    // Bits that software asks to clear this cycle
    assign clr_vec = clr_we ? wdata : '0;

    // Status, enable and mask storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
            en   <= '0;
            mask <= '0;
        end else begin
            stat <= (stat & ~clr_vec) | set_vec;
            if (en_we)   en   <= wdata;
            if (mask_we) mask <= wdata;
        end
    end

    // Interrupt line from enabled, unmasked flags
    assign irq = |(stat & en & ~mask);
endmodule

// File: rtl/pdsc_top.sv
// Power domain sequencing controller top: register decode, per-domain
// sequencers, global ready flags, one-shot error injection and the interrupt
// block. Assumes a single bus master that issues at most one access per cycle.
module pdsc_top
    import pdsc_pkg::*;
#(
    parameter int LATENCY = 8,
    parameter int CH_BIT  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          err_inject,
    output logic          irq
);
    localparam word_t CMD_WORD = word_t'(1) << CH_BIT;

    logic [NDOM-1:0] busy, dir_on, is_off, err, done;
    logic [NDOM-1:0] try_off, try_on, go_off, go_on, fail;
    logic            ready_off, ready_on, armed, attempt;
    word_t           set_vec, istat, ien, imask, rd_mux;

    // Global ready flags: a direction is blocked while any domain runs it
    assign ready_off = ~|(busy & ~dir_on);
    assign ready_on  = ~|(busy & dir_on);

    // Command decode and split into accepted or injected-failure strobes
    always_comb begin
        try_off = '0;
        try_on  = '0;
        for (int d = 0; d < NDOM; d++) begin
            try_off[d] = bus_wr && (bus_addr == dom_base(d) + O_OFF) &&
                         (bus_wdata == CMD_WORD) && ready_off && !busy[d];
            try_on[d]  = bus_wr && (bus_addr == dom_base(d) + O_ON) &&
                         (bus_wdata == CMD_WORD) && ready_on && !busy[d];
        end
        attempt = |(try_off | try_on);
        go_off  = armed ? '0 : try_off;
        go_on   = armed ? '0 : try_on;
        fail    = armed ? (try_off | try_on) : '0;
    end

    // One-shot failure arming; a new pulse outranks consumption
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= (armed && !attempt) || err_inject;
    end

    // Per-domain sequencers
    for (genvar g = 0; g < NDOM; g++) begin : g_dom
        pdsc_domain #(.LATENCY(LATENCY)) u_dom (
            .clk    (clk),
            .rst_n  (rst_n),
            .go_off (go_off[g]),
            .go_on  (go_on[g]),
            .fail   (fail[g]),
            .is_off (is_off[g]),
            .busy   (busy[g]),
            .dir_on (dir_on[g]),
            .err    (err[g]),
            .done   (done[g])
        );
    end

    // Place completion strobes at their interrupt-status positions
    always_comb begin
        set_vec = '0;
        for (int d = 0; d < NDOM; d++) begin
            set_vec[dom_irq_bit(d)] = done[d];
        end
    end

    pdsc_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_we  (bus_wr && (bus_addr == A_ICLR)),
        .en_we   (bus_wr && (bus_addr == A_IEN)),
        .mask_we (bus_wr && (bus_addr == A_IMASK)),
        .wdata   (bus_wdata),
        .stat    (istat),
        .en      (ien),
        .mask    (imask),
        .irq     (irq)
    );

    // Read multiplexer; unlisted addresses return zero
    always_comb begin
        rd_mux = '0;
        if (bus_addr == A_READY)      rd_mux = word_t'({ready_on, ready_off});
        else if (bus_addr == A_ISTAT) rd_mux = istat;
        else if (bus_addr == A_IEN)   rd_mux = ien;
        else if (bus_addr == A_IMASK) rd_mux = imask;
        for (int d = 0; d < NDOM; d++) begin
            if (bus_addr == dom_base(d) + O_STAT) rd_mux[CH_BIT] = is_off[d];
            if (bus_addr == dom_base(d) + O_ERR)  rd_mux[CH_BIT] = err[d];
        end
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/pdsc_checker.sv
// Temporal checks on the controller's sequencers and completion flags,
// attached to every pdsc_top instance by the bind below.
module pdsc_checker
    import pdsc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic [NDOM-1:0] busy,
    input logic [NDOM-1:0] dir_on,
    input logic [NDOM-1:0] is_off,
    input logic [NDOM-1:0] done,
    input logic [NDOM-1:0] fail,
    input word_t           istat
);
    for (genvar g = 0; g < NDOM; g++) begin : g_chk
        localparam int B = dom_irq_bit(g);

        AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            done[g] |=> istat[B]); // R5

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (istat[B] && !(bus_wr && bus_addr == A_ICLR && bus_wdata[B])) |=> istat[B]); // R6

        AST_DONE_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
            done[g] |=> (is_off[g] == !$past(dir_on[g]))); // R4

        AST_STATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[g] && !done[g]) |=> $stable(is_off[g])); // R4

        AST_FAIL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
            (fail[g] && !busy[g]) |=> !busy[g]); // R7
    end
endmodule

bind pdsc_top pdsc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .dir_on    (dir_on),
    .is_off    (is_off),
    .done      (done),
    .fail      (fail),
    .istat     (istat)
);

// File: tb/pdsc_top_bench.sv
module pdsc_top_bench;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        err_inject = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #5 clk = ~clk;

    pdsc_top #(.LATENCY(LAT), .CH_BIT(0)) u_pdsc_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_inject(err_inject), .irq(irq)
    );

    // Monitor: a read strobe seen at an edge has its data ready by the next negedge
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (bus_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
            end
        end
    end

    // Driver: one read; the expected word goes to the scoreboard queue
    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        bus_rd   = 1'b1;
        bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq got %b expected %b", t, irq, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R10 read path
        rd(12'h000, 32'h3, "R1 ready after reset");
        rd(12'h004, 32'h0, "R1 istat after reset");
        for (int d = 0; d < 4; d++) begin
            rd(12'h080 + 12'(d * 64), 32'h1, "R1 domain off after reset");
            rd(12'h094 + 12'(d * 64), 32'h0, "R1 error clear after reset");
        end
        rd(12'h00C, 32'h0, "R10 enable readback");
        chk_irq(1'b0, "R1 irq after reset");

        // R3/R4/R5 switch-on of domain 0 with exact timing
        wr(12'h08C, 32'h1);
        rd(12'h000, 32'h1, "R3 on-ready drops");
        rd(12'h080, 32'h1, "R4 status held k2");
        rd(12'h080, 32'h1, "R4 status held k3");
        rd(12'h080, 32'h1, "R4 status held k4");
        rd(12'h080, 32'h1, "R4 status held k5");
        rd(12'h080, 32'h0, "R4 status settles on");
        rd(12'h000, 32'h3, "R3 ready restored");
        rd(12'h004, 32'h0001_0000, "R5 completion bit 16");

        // R11 busy domain, R3 ready low ignores commands
        wr(12'h0CC, 32'h1);
        wr(12'h0C4, 32'h1);
        wr(12'h10C, 32'h1);
        idle(10);
        rd(12'h0C0, 32'h0, "R11 busy-domain command ignored");
        rd(12'h100, 32'h1, "R3 command while not ready ignored");
        rd(12'h004, 32'h0011_0000, "R5 completion bits 16,20");

        // R2 wrong command word
        wr(12'h10C, 32'h2);
        rd(12'h000, 32'h3, "R2 bad word leaves ready");
        idle(8);
        rd(12'h100, 32'h1, "R2 bad word no transition");

        // R6 clear
        wr(12'h008, 32'h0001_0000);
        rd(12'h004, 32'h0010_0000, "R6 clear bit 16");
        wr(12'h008, 32'h0);
        rd(12'h004, 32'h0010_0000, "R6 zero clear no effect");

        // R7 injected failure and retry
        err_inject = 1'b1;
        @(negedge clk);
        err_inject = 1'b0;
        wr(12'h10C, 32'h1);
        rd(12'h114, 32'h1, "R7 error flag set");
        rd(12'h000, 32'h3, "R7 ready unchanged");
        idle(8);
        rd(12'h100, 32'h1, "R7 failed command no effect");
        wr(12'h10C, 32'h1);
        rd(12'h114, 32'h0, "R7 error cleared on retry");
        idle(8);
        rd(12'h100, 32'h0, "R7 retry completes");
        rd(12'h004, 32'h0030_0000, "R5 completion bits 20,21");

        // R8 interrupt line
        chk_irq(1'b0, "R8 irq disabled");
        wr(12'h00C, 32'h0131_000E);
        rd(12'h00C, 32'h0131_000E, "R8 enable readback");
        chk_irq(1'b1, "R8 irq enabled");
        wr(12'h010, 32'hFFFF_FFFF);
        chk_irq(1'b0, "R8 irq masked");
        wr(12'h010, 32'h0);
        chk_irq(1'b1, "R8 irq unmasked");
        wr(12'h008, 32'hFFFF_FFFF);
        chk_irq(1'b0, "R8 irq after clear");
        rd(12'h004, 32'h0, "R6 clear all");

        // R9 unmapped space
        wr(12'h200, 32'hDEAD_BEEF);
        wr(12'h088, 32'h1);
        rd(12'h200, 32'h0, "R9 unmapped read");
        rd(12'h088, 32'h0, "R9 gap in bank reads zero");
        rd(12'h08C, 32'h0, "R9 command register reads zero");
        rd(12'h000, 32'h3, "R9 unmapped write no effect");

        // R6 completion and clear in the same cycle
        wr(12'h14C, 32'h1);
        idle(LAT - 1);
        wr(12'h008, 32'h0100_0000);
        rd(12'h004, 32'h0100_0000, "R6 completion beats clear");
        chk_irq(1'b1, "R8 irq from bit 24");

        // R3 switch-off of domain 0
        wr(12'h084, 32'h1);
        rd(12'h000, 32'h2, "R3 off-ready drops");
        idle(8);
        rd(12'h080, 32'h1, "R4 status settles off");
        rd(12'h004, 32'h0101_0000, "R5 completion bits 16,24");

        idle(3);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule